// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is the target side of a two-wire serial EEPROM. It oversamples the bus clock and data lines with the system clock and finds start and stop conditions. It matches the first byte of each transfer against a fixed device code and three strap inputs. The block then runs write transfers into a page buffer, or serves read transfers from an internal byte array. The data line is open-drain: the block only asserts a pull-low enable, and the board or bench supplies the pull-up.

A write names a two-byte memory address and then streams data bytes into a page buffer. When a stop follows at least one data byte, a timed internal write cycle moves the buffered bytes into the array. While that cycle runs, the block refuses its own device address, so a host polls until it is acknowledged again. Reads start from an internal address counter. The host moves that counter with a dummy write to do a random read, and it can keep acknowledging to read bytes in sequence.

The array holds 2^MEM_AW bytes (MEM_AW = 13 gives 8K; the default is smaller). Address bits above MEM_AW are dropped. The write cycle length is WR_CYCLES system clocks.

Top module: `twi_eeprom_target`

## Requirements
- R1: A falling data line while the bus clock is high is a start, and a rising data line while the clock is high is a stop. A start restarts byte and bit counting in any state. A stop releases the data line and returns the block to idle. After reset the data line is released.
- R2: The first byte after a start is compared as follows: bits 7..4 against DEV_CODE (default 4'b1010), bits 3..1 against the strap inputs, and bit 0 selects read (1) or write (0). On any mismatch the block gives no acknowledge and ignores the bus until the next start.
- R3: Bytes move most significant bit first. Incoming bits are taken on the rising clock edge, and the data line pull changes only after a falling clock edge. The block acknowledges by pulling low through the ninth clock and releases the line afterwards.
- R4: A write transfer is the device byte, the high address byte, the low address byte, then data bytes. The block acknowledges every one of these bytes. The memory address is the low MEM_AW bits of {high, low}.
- R5: Within one write transfer the low PAGE_AW address bits (32-byte pages by default) wrap inside the current page. A slot written more than once keeps its latest byte.
- R6: A stop that follows at least one data byte starts a write cycle of WR_CYCLES clocks. A stop after only the address bytes starts no cycle and sets the address counter. A start arriving before the stop throws away the buffered data.
- R7: While the write cycle runs, the device byte is not acknowledged. The first poll after the cycle is acknowledged, and the written data can then be read back.
- R8: After a write cycle the address counter equals the address of the last data byte written plus one.
- R9: A read device byte returns the byte at the address counter. The counter advances after each byte sent.
- R10: A dummy write of the device byte and two address bytes, then a repeated start with a read device byte, returns the byte at that address.
- R11: A host acknowledge after a read byte sends the next byte. A host no-acknowledge ends the read. During reads the counter wraps from the top address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sel_strap_i | input | 3 | Device select straps |
| sda_low_o | output | 1 | Pull-low enable for the open-drain data line |

## Verification
The assertions assume that the bus clock and data lines are held for several system clocks between changes. They also assume the host changes the data line only while the clock is low, except for intended starts and stops. The bench host drives each bus phase for a quarter-bit of five system clocks and models the wired-AND line. As a result, every bit edge reaches the synchronizer cleanly and the block's response settles well before the host samples. The bench also makes its first poll soon after the stop, so that it lands inside the write cycle.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RX, ST_TX} bus_st_e;
    typedef enum logic [1:0] {RL_DEV, RL_AHI, RL_ALO, RL_DATA} role_e;
    localparam logic [3:0] DEV_CODE_DEF = 4'b1010;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    // [0] first flop, [1] synchronized, [2] previous synchronized value
    logic [2:0] scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    assign sda_o   = sda_q[1];
    assign rise_o  = scl_q[1] & ~scl_q[2];
    assign fall_o  = ~scl_q[1] & scl_q[2];
    assign start_o = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_o  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/twi_page_buf.sv
module twi_page_buf #(
    parameter int PAGE_AW = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               we_i,
    input  logic [PAGE_AW-1:0] wa_i,
    input  logic [7:0]         wd_i,
    input  logic [PAGE_AW-1:0] ra_i,
    output logic [7:0]         rd_o,
    output logic               rv_o
);
    localparam int PAGE_N = 1 << PAGE_AW;

    logic [7:0]        slot_w [PAGE_N];
    logic [PAGE_N-1:0] vld_w;

    for (genvar g = 0; g < PAGE_N; g++) begin : g_slot
        logic [7:0] data_q;
        logic       vld_q;
        logic       hit;
        assign hit = we_i && (wa_i == PAGE_AW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     vld_q <= 1'b0;
            else if (clr_i) vld_q <= 1'b0;
            else if (hit)   vld_q <= 1'b1;
        end

        always_ff @(posedge clk) begin
            if (hit && !clr_i) data_q <= wd_i;
        end

        assign slot_w[g] = data_q;
        assign vld_w[g]  = vld_q;
    end

    assign rd_o = slot_w[ra_i];
    assign rv_o = vld_w[ra_i];

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (vld_w == '0)); // R6
    AST_SLOT_LATEST: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !clr_i) |=> (vld_w[$past(wa_i)] && slot_w[$past(wa_i)] == $past(wd_i))); // R5
endmodule

// File: rtl/twi_mem_array.sv
module twi_mem_array #(
    parameter int MEM_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [MEM_AW-1:0] wa_i,
    input  logic [7:0]        wd_i,
    input  logic [MEM_AW-1:0] ra_i,
    output logic [7:0]        rd_o
);
    localparam int DEPTH = 1 << MEM_AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[wa_i] <= wd_i;
    end

    assign rd_o = mem_q[ra_i];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(wa_i)] == $past(wd_i))); // R7
endmodule

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target
    import twi_eeprom_pkg::*;
#(
    parameter int         MEM_AW    = 10,
    parameter int         PAGE_AW   = 5,
    parameter int         WR_CYCLES = 400,
    parameter logic [3:0] DEV_CODE  = DEV_CODE_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] sel_strap_i,
    output logic       sda_low_o
);
    localparam int PAGE_N = 1 << PAGE_AW;
    localparam int WC_W   = $clog2(WR_CYCLES + 1);
    localparam int HI_W   = MEM_AW - 8;

    initial begin
        if (MEM_AW < 9 || MEM_AW > 16) $error("MEM_AW must lie in 9..16");
        if (WR_CYCLES <= PAGE_N)       $error("WR_CYCLES must exceed the page size");
    end

    typedef struct packed {
        bus_st_e           st;
        role_e             role;
        logic              rd;
        logic [3:0]        bcnt;
        logic [7:0]        sh;
        logic              low;
        logic              hnak;
        logic [HI_W-1:0]   ahi;
        logic [MEM_AW-1:0] addr;
        logic [MEM_AW-1:0] last;
        logic              pend;
        logic              busy;
        logic [WC_W-1:0]   wcnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic sda_s, ev_rise, ev_fall, ev_start, ev_stop;
    logic pb_clr, pb_we, pb_rv;
    logic [7:0] pb_rd, mem_rd;
    logic mem_we;
    logic [MEM_AW-1:0] mem_wa;

    twi_line_sync u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_o(sda_s), .rise_o(ev_rise), .fall_o(ev_fall),
        .start_o(ev_start), .stop_o(ev_stop)
    );

    twi_page_buf #(.PAGE_AW(PAGE_AW)) u_page (
        .clk(clk), .rst_n(rst_n), .clr_i(pb_clr), .we_i(pb_we),
        .wa_i(ctl_q.addr[PAGE_AW-1:0]), .wd_i(ctl_q.sh),
        .ra_i(ctl_q.wcnt[PAGE_AW-1:0]), .rd_o(pb_rd), .rv_o(pb_rv)
    );

    twi_mem_array #(.MEM_AW(MEM_AW)) u_mem (
        .clk(clk), .rst_n(rst_n), .we_i(mem_we), .wa_i(mem_wa), .wd_i(pb_rd),
        .ra_i(ctl_q.addr), .rd_o(mem_rd)
    );

    assign mem_wa = {ctl_q.addr[MEM_AW-1:PAGE_AW], ctl_q.wcnt[PAGE_AW-1:0]};

    always_comb begin
        ctl_d  = ctl_q;
        pb_we  = 1'b0;
        pb_clr = 1'b0;
        mem_we = 1'b0;

        // internal write cycle: one page slot committed per clock, then wait
        if (ctl_q.busy) begin
            if (ctl_q.wcnt < WC_W'(PAGE_N)) mem_we = pb_rv;
            if (ctl_q.wcnt == WC_W'(WR_CYCLES - 1)) begin
                ctl_d.busy = 1'b0;
                ctl_d.wcnt = '0;
                ctl_d.addr = ctl_q.last + MEM_AW'(1);
                pb_clr     = 1'b1;
            end else begin
                ctl_d.wcnt = ctl_q.wcnt + WC_W'(1);
            end
        end

        if (ev_start) begin
            ctl_d.st   = ST_RX;
            ctl_d.role = RL_DEV;
            ctl_d.bcnt = '0;
            ctl_d.low  = 1'b0;
            if (ctl_q.pend) begin
                pb_clr     = 1'b1;
                ctl_d.pend = 1'b0;
            end
        end else if (ev_stop) begin
            ctl_d.st   = ST_IDLE;
            ctl_d.bcnt = '0;
            ctl_d.low  = 1'b0;
            if (ctl_q.pend) begin
                ctl_d.pend = 1'b0;
                ctl_d.busy = 1'b1;
                ctl_d.wcnt = '0;
            end
        end else begin
            if (ev_rise && ctl_q.st != ST_IDLE && ctl_q.bcnt < 4'd9) begin
                ctl_d.bcnt = ctl_q.bcnt + 4'd1;
                if (ctl_q.st == ST_RX && ctl_q.bcnt < 4'd8)
                    ctl_d.sh = {ctl_q.sh[6:0], sda_s};
                if (ctl_q.st == ST_TX && ctl_q.bcnt == 4'd8)
                    ctl_d.hnak = sda_s;
            end
            if (ev_fall) begin
                if (ctl_q.st == ST_RX) begin
                    if (ctl_q.bcnt == 4'd8) begin
                        case (ctl_q.role)
                            RL_DEV: begin
                                if (ctl_q.sh[7:4] == DEV_CODE && ctl_q.sh[3:1] == sel_strap_i
                                    && !ctl_q.busy) begin
                                    ctl_d.low = 1'b1;
                                    ctl_d.rd  = ctl_q.sh[0];
                                end else begin
                                    ctl_d.st = ST_IDLE;
                                end
                            end
                            RL_AHI: begin
                                ctl_d.low = 1'b1;
                                ctl_d.ahi = ctl_q.sh[HI_W-1:0];
                            end
                            RL_ALO: begin
                                ctl_d.low  = 1'b1;
                                ctl_d.addr = {ctl_q.ahi, ctl_q.sh};
                            end
                            default: begin
                                ctl_d.low  = 1'b1;
                                pb_we      = 1'b1;
                                ctl_d.pend = 1'b1;
                                ctl_d.last = ctl_q.addr;
                                ctl_d.addr = {ctl_q.addr[MEM_AW-1:PAGE_AW],
                                              ctl_q.addr[PAGE_AW-1:0] + PAGE_AW'(1)};
                            end
                        endcase
                    end else if (ctl_q.bcnt == 4'd9) begin
                        ctl_d.low  = 1'b0;
                        ctl_d.bcnt = '0;
                        case (ctl_q.role)
                            RL_DEV: begin
                                if (ctl_q.rd) begin
                                    ctl_d.st  = ST_TX;
                                    ctl_d.sh  = mem_rd;
                                    ctl_d.low = ~mem_rd[7];
                                end else begin
                                    ctl_d.role = RL_AHI;
                                end
                            end
                            RL_AHI:  ctl_d.role = RL_ALO;
                            RL_ALO:  ctl_d.role = RL_DATA;
                            default: ctl_d.role = RL_DATA;
                        endcase
                    end
                end else if (ctl_q.st == ST_TX) begin
                    if (ctl_q.bcnt >= 4'd1 && ctl_q.bcnt <= 4'd7) begin
                        ctl_d.sh  = {ctl_q.sh[6:0], 1'b0};
                        ctl_d.low = ~ctl_q.sh[6];
                    end else if (ctl_q.bcnt == 4'd8) begin
                        ctl_d.low  = 1'b0;
                        ctl_d.addr = ctl_q.addr + MEM_AW'(1);
                    end else if (ctl_q.bcnt == 4'd9) begin
                        if (ctl_q.hnak) begin
                            ctl_d.st = ST_IDLE;
                        end else begin
                            ctl_d.bcnt = '0;
                            ctl_d.sh   = mem_rd;
                            ctl_d.low  = ~mem_rd[7];
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sda_low_o = ctl_q.low;

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (!sda_low_o && ctl_q.st == ST_IDLE)); // R1
    AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_low_o) |-> $past(ev_fall)); // R3
    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fall && ctl_q.st == ST_RX && ctl_q.role == RL_DEV && ctl_q.bcnt == 4'd8
         && ctl_q.busy) |=> !sda_low_o); // R7
    AST_CYCLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.busy |-> (ctl_q.wcnt < WC_W'(WR_CYCLES))); // R6
    AST_ADDR_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.busy |=> (!ctl_q.busy || $stable(ctl_q.addr))); // R8
endmodule

// File: tb/twi_eeprom_target_bench.sv
module twi_eeprom_target_bench;
    localparam int CLK_P = 10;
    localparam int Q     = 5;
    localparam int AW    = 10;
    localparam logic [2:0] SEL = 3'b101;
    localparam logic [7:0] DEVW = {4'hA, SEL, 1'b0};
    localparam logic [7:0] DEVR = {4'hA, SEL, 1'b1};
    localparam logic [15:0] TOP = 16'((1 << AW) - 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic dut_low;
    logic sda_line;
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    logic [7:0] rbuf [8];

    assign sda_line = !(m_low || dut_low);

    always #(CLK_P/2) clk = ~clk;

    twi_eeprom_target #(.MEM_AW(AW), .PAGE_AW(5), .WR_CYCLES(400)) u_twi_eeprom_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sel_strap_i(SEL), .sda_low_o(dut_low)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish (got %0d cycles, expected fewer)", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_low = 1'b0; wq(); scl = 1'b1; wq(); m_low = 1'b1; wq(); scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wq(); scl = 1'b1; wq(); m_low = 1'b0; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = !b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        end
        m_low = 1'b0; wq(); scl = 1'b1; wq(); ack = sda_line; wq(); scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        b = '0;
        for (int i = 0; i < 8; i++) begin
            m_low = 1'b0; wq(); scl = 1'b1; wq(); b = {b[6:0], sda_line}; wq(); scl = 1'b0; wq();
        end
        m_low = give_ack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
        m_low = 1'b0;
    endtask

    // start, device write byte, two address bytes; no stop
    task automatic set_addr(input logic [15:0] a, input string req);
        logic ack;
        bus_start();
        send_byte(DEVW, ack);  chk(req, {7'd0, ack}, 8'd0);
        send_byte(a[15:8], ack); chk(req, {7'd0, ack}, 8'd0);
        send_byte(a[7:0], ack);  chk(req, {7'd0, ack}, 8'd0);
    endtask

    // poll until acknowledged; returns number of attempts
    task automatic poll(output int n);
        logic ack;
        n = 0;
        ack = 1'b1;
        while (ack && n < 20) begin
            bus_start(); send_byte(DEVW, ack); bus_stop(); n++;
        end
    endtask

    task automatic write_block(input logic [15:0] a, input int n, input logic [7:0] v0);
        logic ack;
        int np;
        set_addr(a, "R4 address ack");
        for (int i = 0; i < n; i++) begin
            send_byte(v0 + 8'(i), ack);
            chk("R4 data ack", {7'd0, ack}, 8'd0);
        end
        bus_stop();
        poll(np);
        checks++;
        if (!(np > 1 && np < 20)) begin
            fails++;
            $display("FAIL R7: poll attempts got %0d expected between 2 and 19", np);
        end
    endtask

    // dummy write then repeated start and read of n bytes
    task automatic rand_read(input logic [15:0] a, input int n);
        logic ack;
        set_addr(a, "R10 dummy write ack");
        bus_start();
        send_byte(DEVR, ack);
        chk("R10 read device ack", {7'd0, ack}, 8'd0);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        chk("R3 line released after nack", {7'd0, dut_low}, 8'd0);
        bus_stop();
    endtask

    task automatic cur_read(input string req, input logic [7:0] exp);
        logic ack;
        logic [7:0] b;
        bus_start();
        send_byte(DEVR, ack);
        chk(req, {7'd0, ack}, 8'd0);
        recv_byte(1'b0, b);
        chk(req, b, exp);
        bus_stop();
    endtask

    task automatic t_reset();
        chk("R1 released after reset", {7'd0, dut_low}, 8'd0);
        chk("R1 line idle high", {7'd0, sda_line}, 8'd1);
    endtask

    task automatic t_bad_addr();
        logic ack;
        bus_start();
        send_byte({4'hA, 3'b001, 1'b0}, ack);
        chk("R2 wrong strap nack", {7'd0, ack}, 8'd1);
        send_byte(8'h00, ack);
        chk("R2 ignored until start", {7'd0, ack}, 8'd1);
        bus_stop();
        bus_start();
        send_byte({4'hB, SEL, 1'b0}, ack);
        chk("R2 wrong code nack", {7'd0, ack}, 8'd1);
        bus_stop();
    endtask

    task automatic t_byte_write();
        write_block(16'h0123, 2, 8'hA5);
        write_block(16'h0200, 1, 8'h11);
        rand_read(16'h0123, 1);
        chk("R10 random read 0x123", rbuf[0], 8'hA5);
        rand_read(16'h0200, 1);
        chk("R10 random read 0x200", rbuf[0], 8'h11);
    endtask

    task automatic t_dummy_and_current();
        int np;
        set_addr(16'h0123, "R6 dummy address ack");
        bus_stop();
        cur_read("R6 no cycle, R9 current read", 8'hA5);
        cur_read("R9 counter advanced", 8'hA6);
        poll(np);
        chk("R6 no cycle after address only", 8'(np), 8'd1);
    endtask

    task automatic t_abort();
        logic ack;
        int np;
        set_addr(16'h0200, "R6 abort address ack");
        send_byte(8'h99, ack);
        bus_start();
        send_byte(DEVW, ack);
        chk("R6 restart not busy", {7'd0, ack}, 8'd0);
        bus_stop();
        poll(np);
        chk("R6 discarded data no cycle", 8'(np), 8'd1);
        rand_read(16'h0200, 1);
        chk("R6 data unchanged", rbuf[0], 8'h11);
    endtask

    task automatic t_page_rewrite();
        write_block(16'h0080, 33, 8'h10);
        cur_read("R8 counter after write", 8'h11);
        rand_read(16'h0080, 2);
        chk("R5 slot keeps latest", rbuf[0], 8'h30);
        chk("R5 next slot", rbuf[1], 8'h11);
        rand_read(16'h009F, 1);
        chk("R5 last slot of page", rbuf[0], 8'h2F);
    endtask

    task automatic t_page_wrap();
        write_block(16'h005C, 6, 8'hC0);
        rand_read(16'h005C, 4);
        for (int i = 0; i < 4; i++) chk("R11 sequential read", rbuf[i], 8'hC0 + 8'(i));
        rand_read(16'h0040, 2);
        chk("R5 wrap to page start", rbuf[0], 8'hC4);
        chk("R5 wrap second byte", rbuf[1], 8'hC5);
    endtask

    task automatic t_top_wrap();
        write_block(TOP, 1, 8'h77);
        write_block(16'h0000, 1, 8'h88);
        rand_read(TOP, 2);
        chk("R11 top byte", rbuf[0], 8'h77);
        chk("R11 wrap to zero", rbuf[1], 8'h88);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (5) @(posedge clk);
        #1;
        t_reset();
        t_bad_addr();
        t_byte_write();
        t_dummy_and_current();
        t_abort();
        t_page_rewrite();
        t_page_wrap();
        t_top_wrap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule